// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR-style flash bus. It turns one high-level request into the full sequence of bus cycles that the flash expects. A request can be a word read, a word program, a sector erase or a whole-array erase. The block times every write and read strobe in system clock cycles. After a program or erase it polls until the operation is complete and then returns a single response to the requester.

Requests arrive on a valid/ready port that carries an opcode, an address and a data word. Only one request is in flight at a time. Completion is gated first by the flash's ready/busy line. It is then confirmed by a status read at the target address, whose bit 7 must equal the value the operation leaves behind. If the operation does not finish within a per-operation microsecond limit, the block pulses the flash reset line, reports a timeout and returns to idle. The same reset pulse is issued once after system reset, before the first request is accepted.

States: FRST (flash reset pulse), IDLE (accepting), WLO (write strobe low), WHI (write strobe high gap), WAIT (waiting for ready), RLO (read strobe low), RHI (gap between status reads), RESP (one-cycle response). Transitions: FRST to IDLE after power-up, or FRST to RESP after a timeout. IDLE goes to RLO for a read and to WLO for any other opcode. WLO to WHI. WHI goes back to WLO for the next step, or to WAIT after the last step. WAIT goes to RLO when the flash is ready, or to FRST on timeout. RLO goes to RESP when the read is done or the status bit matches, and otherwise to RHI. RHI goes to WAIT, or to FRST on timeout. RESP goes to IDLE.

Top module: `flash_seq`

## Requirements
- R1: After system reset, fl_rst_n is held low for at least ceil(RST_NS/CLK_NS) cycles (63 at defaults). cmd_ready stays low during that time. fl_we_n, fl_oe_n and fl_ce_n are high.
- R2: Opcode 1 (program) issues exactly four writes as (address, data): (5555h, 00AAh), (2AAAh, 0055h), (5555h, 00A0h), then (target address, request data).
- R3: Opcode 2 (sector erase) issues exactly six writes: (5555h, 00AAh), (2AAAh, 0055h), (5555h, 0080h), (5555h, 00AAh), (2AAAh, 0055h), (target address, 0030h).
- R4: Opcode 3 (chip erase) issues the same first five writes as R3, and the sixth write is (5555h, 0010h).
- R5: Each write holds fl_we_n low for exactly ceil(WE_LO_NS/CLK_NS) cycles (6). fl_ce_n is low and fl_addr and fl_dq_out are stable throughout. Consecutive write strobes are separated by at least ceil(WE_HI_NS/CLK_NS) high cycles (3).
- R6: Opcode 0 (read) issues no write and performs one read strobe. fl_oe_n and fl_ce_n are low for ceil(RD_NS/CLK_NS) cycles (12). The word on fl_dq_in at the end of the strobe is returned on rsp_rdata, with rsp_timeout low.
- R7: After the last write of a program or erase, the block does not respond while fl_ready is low. Once fl_ready is high, it reads the target address. It responds only when bit 7 of the read equals the expected value: bit 7 of the request data for a program, 1 for an erase. Otherwise it waits and reads again.
- R8: If a program or erase is not complete within its microsecond limit (PROG_TMO_US, SECT_TMO_US, CHIP_TMO_US), fl_rst_n is pulsed low for at least 63 cycles. The block then responds with rsp_timeout high and accepts new requests again.
- R9: cmd_ready is low from the cycle after a request is accepted until the cycle after the response. Requests offered during that time cause no bus activity.
- R10: Every accepted request produces exactly one response, and rsp_valid is high for exactly one cycle.
- R11: fl_we_n and fl_oe_n are never low together, and fl_dq_oe is never high while fl_oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Block is idle and accepts a request |
| cmd_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| cmd_addr | input | AW | Target word or sector address |
| cmd_wdata | input | DW | Word to program |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_timeout | output | 1 | Response reports a timeout |
| rsp_rdata | output | DW | Last word read from the flash |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Data driven to the flash |
| fl_dq_oe | output | 1 | Enable for fl_dq_out onto the shared data bus |
| fl_dq_in | input | DW | Data read from the flash |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_ready | input | 1 | Flash ready/busy line, high when ready |
| fl_rst_n | output | 1 | Flash reset, active low |

## Verification
The assertions check the per-cycle bus rules on every clock. These are the exact write-strobe width, chip select and stable address and data during a strobe, no overlap of write and read strobes, no data drive during a read, and cmd_ready being low during flash reset and after acceptance. A one-cycle response is checked the same way. Only the bench scenarios can show the rest. That covers the order and content of each unlock sequence, the return of read data, and that completion waits for both ready and a matching status bit. It also covers polls being repeated while the status bit is still inverted, the timeout limit and the reset pulse that follows it, and that requests offered while busy are dropped.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_CHIP = 2'd3
    } fop_e;

    typedef enum logic [3:0] {
        S_FRST, S_IDLE, S_WLO, S_WHI, S_WAIT, S_RLO, S_RHI, S_RESP
    } fst_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fseq_cmd_rom.sv
module fseq_cmd_rom
    import flash_seq_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 16
) (
    input  fop_e            op,
    input  logic [2:0]      step,
    input  logic [AW-1:0]   tgt_addr,
    input  logic [DW-1:0]   tgt_data,
    output logic [AW-1:0]   wr_addr,
    output logic [DW-1:0]   wr_data,
    output logic [2:0]      last_step
);
    localparam logic [AW-1:0] A_ODD  = AW'(16'h5555);
    localparam logic [AW-1:0] A_EVEN = AW'(16'h2AAA);

    always_comb begin
        wr_addr   = A_ODD;
        wr_data   = '0;
        last_step = (op == OP_PROG) ? 3'd3 : 3'd5;
        if (op == OP_PROG) begin
            case (step)
                3'd0:    begin wr_addr = A_ODD;  wr_data = DW'(8'hAA); end
                3'd1:    begin wr_addr = A_EVEN; wr_data = DW'(8'h55); end
                3'd2:    begin wr_addr = A_ODD;  wr_data = DW'(8'hA0); end
                default: begin wr_addr = tgt_addr; wr_data = tgt_data; end
            endcase
        end else begin
            case (step)
                3'd0:    begin wr_addr = A_ODD;  wr_data = DW'(8'hAA); end
                3'd1:    begin wr_addr = A_EVEN; wr_data = DW'(8'h55); end
                3'd2:    begin wr_addr = A_ODD;  wr_data = DW'(8'h80); end
                3'd3:    begin wr_addr = A_ODD;  wr_data = DW'(8'hAA); end
                3'd4:    begin wr_addr = A_EVEN; wr_data = DW'(8'h55); end
                default: begin
                    if (op == OP_SECT) begin
                        wr_addr = tgt_addr; wr_data = DW'(8'h30);
                    end else begin
                        wr_addr = A_ODD;    wr_data = DW'(8'h10);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/fseq_us_timer.sv
module fseq_us_timer #(
    parameter int TICK_CYC = 125,
    parameter int LIMW     = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    input  logic [LIMW-1:0] limit,
    output logic            expired
);
    localparam int PW = $clog2(TICK_CYC) + 1;

    logic [PW-1:0]   pre_q;
    logic [LIMW-1:0] us_q;

    assign expired = (us_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (clr) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (run) begin
            if (pre_q == PW'(TICK_CYC - 1)) begin
                pre_q <= '0;
                if (!expired) us_q <= us_q + LIMW'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int          AW          = 21,
    parameter int          DW          = 16,
    parameter int          CLK_NS      = 8,
    parameter int          WE_LO_NS    = 45,
    parameter int          WE_HI_NS    = 20,
    parameter int          RD_NS       = 90,
    parameter int          RST_NS      = 500,
    parameter int unsigned PROG_TMO_US = 300,
    parameter int unsigned SECT_TMO_US = 15_000_000,
    parameter int unsigned CHIP_TMO_US = 256_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          rsp_valid,
    output logic          rsp_timeout,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    input  logic          fl_ready,
    output logic          fl_rst_n
);
    localparam int WE_LO_CYC = ceil_div(WE_LO_NS, CLK_NS);
    localparam int WE_HI_CYC = ceil_div(WE_HI_NS, CLK_NS);
    localparam int RD_CYC    = ceil_div(RD_NS, CLK_NS);
    localparam int RST_CYC   = ceil_div(RST_NS, CLK_NS);
    localparam int TICK_CYC  = ceil_div(1000, CLK_NS);
    localparam int MAX_CYC   = imax(imax(RST_CYC, RD_CYC), imax(WE_LO_CYC, WE_HI_CYC));
    localparam int CW        = $clog2(MAX_CYC + 1);
    localparam int MAX_TMO   = imax(imax(int'(PROG_TMO_US), int'(SECT_TMO_US)), int'(CHIP_TMO_US));
    localparam int LIMW      = $clog2(MAX_TMO + 1) + 1;

    fst_e          state, state_d;
    logic [CW-1:0] cnt, cnt_ld;
    logic [2:0]    step, step_d;
    fop_e          op_q, op_n;
    logic [AW-1:0] addr_q, addr_n;
    logic [DW-1:0] data_q, data_n, rdata_q;
    logic          tmo_q;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_data;
    logic [2:0]    last_step;
    logic [LIMW-1:0] tmo_lim;
    logic          tmo_hit;
    logic          exp7;

    assign op_n   = (state == S_IDLE) ? fop_e'(cmd_op) : op_q;
    assign addr_n = (state == S_IDLE) ? cmd_addr : addr_q;
    assign data_n = (state == S_IDLE) ? cmd_wdata : data_q;
    assign exp7   = (op_q == OP_PROG) ? data_q[7] : 1'b1;

    fseq_cmd_rom #(.AW(AW), .DW(DW)) u_rom (
        .op(op_n), .step(step_d), .tgt_addr(addr_n), .tgt_data(data_n),
        .wr_addr(rom_addr), .wr_data(rom_data), .last_step(last_step)
    );

    always_comb begin
        case (op_q)
            OP_PROG: tmo_lim = LIMW'(PROG_TMO_US);
            OP_SECT: tmo_lim = LIMW'(SECT_TMO_US);
            default: tmo_lim = LIMW'(CHIP_TMO_US);
        endcase
    end

    fseq_us_timer #(.TICK_CYC(TICK_CYC), .LIMW(LIMW)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .clr(state == S_IDLE),
        .run(state == S_WAIT || state == S_RLO || state == S_RHI),
        .limit(tmo_lim), .expired(tmo_hit)
    );

    // next state
    always_comb begin
        state_d = state;
        step_d  = step;
        unique case (state)
            S_FRST: if (cnt == '0) state_d = tmo_q ? S_RESP : S_IDLE;
            S_IDLE: if (cmd_valid) begin
                step_d  = 3'd0;
                state_d = (fop_e'(cmd_op) == OP_READ) ? S_RLO : S_WLO;
            end
            S_WLO:  if (cnt == '0) state_d = S_WHI;
            S_WHI:  if (cnt == '0) begin
                if (step == last_step) begin
                    state_d = S_WAIT;
                end else begin
                    step_d  = step + 3'd1;
                    state_d = S_WLO;
                end
            end
            S_WAIT: begin
                if (tmo_hit)       state_d = S_FRST;
                else if (fl_ready) state_d = S_RLO;
            end
            S_RLO:  if (cnt == '0)
                state_d = (op_q == OP_READ || fl_dq_in[7] == exp7) ? S_RESP : S_RHI;
            S_RHI:  if (cnt == '0) state_d = tmo_hit ? S_FRST : S_WAIT;
            S_RESP: state_d = S_IDLE;
            default: state_d = S_FRST;
        endcase
    end

    always_comb begin
        unique case (state_d)
            S_FRST:  cnt_ld = CW'(RST_CYC - 1);
            S_WLO:   cnt_ld = CW'(WE_LO_CYC - 1);
            S_WHI:   cnt_ld = CW'(WE_HI_CYC - 1);
            S_RLO:   cnt_ld = CW'(RD_CYC - 1);
            S_RHI:   cnt_ld = CW'(WE_HI_CYC - 1);
            default: cnt_ld = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_FRST;
            cnt     <= CW'(RST_CYC - 1);
            step    <= '0;
            op_q    <= OP_READ;
            addr_q  <= '0;
            data_q  <= '0;
            tmo_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state <= state_d;
            step  <= step_d;
            if (state_d != state)  cnt <= cnt_ld;
            else if (cnt != '0)    cnt <= cnt - CW'(1);
            if (state == S_IDLE && cmd_valid) begin
                op_q   <= fop_e'(cmd_op);
                addr_q <= cmd_addr;
                data_q <= cmd_wdata;
                tmo_q  <= 1'b0;
            end
            if (state_d == S_FRST && state != S_FRST) tmo_q <= 1'b1;
            if (state == S_RLO && cnt == '0) rdata_q <= fl_dq_in;
        end
    end

    // registered pin outputs from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_we_n   <= 1'b1;
            fl_ce_n   <= 1'b1;
            fl_oe_n   <= 1'b1;
            fl_rst_n  <= 1'b0;
            fl_dq_oe  <= 1'b0;
            fl_addr   <= '0;
            fl_dq_out <= '0;
        end else begin
            fl_we_n  <= (state_d != S_WLO);
            fl_ce_n  <= !(state_d == S_WLO || state_d == S_RLO);
            fl_oe_n  <= (state_d != S_RLO);
            fl_rst_n <= (state_d != S_FRST);
            fl_dq_oe <= (state_d == S_WLO || state_d == S_WHI);
            if (state_d == S_WLO) begin
                fl_addr   <= rom_addr;
                fl_dq_out <= rom_data;
            end else if (state_d == S_RLO) begin
                fl_addr   <= addr_n;
            end
        end
    end

    assign cmd_ready   = (state == S_IDLE);
    assign rsp_valid   = (state == S_RESP);
    assign rsp_timeout = tmo_q;
    assign rsp_rdata   = rdata_q;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
    parameter int AW        = 21,
    parameter int DW        = 16,
    parameter int WE_LO_CYC = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          rsp_valid,
    input logic          fl_we_n,
    input logic          fl_oe_n,
    input logic          fl_ce_n,
    input logic          fl_rst_n,
    input logic          fl_dq_oe,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_dq_out
);
    logic [15:0] lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lo_run <= '0;
        else if (!fl_we_n) lo_run <= lo_run + 16'd1;
        else               lo_run <= '0;
    end

    a_r5_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (lo_run == 16'(WE_LO_CYC)));

    a_r5_ce_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> !fl_ce_n);

    a_r5_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    a_r11_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));

    a_r11_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_dq_oe);

    a_r1_no_accept_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_rst_n |-> (!cmd_ready && fl_we_n && fl_oe_n));

    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r10_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_not_ready_at_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

endmodule

bind flash_seq flash_seq_chk #(.AW(AW), .DW(DW), .WE_LO_CYC(WE_LO_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_ce_n(fl_ce_n),
    .fl_rst_n(fl_rst_n), .fl_dq_oe(fl_dq_oe), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out)
);

// File: tb/flash_seq_tb.sv
module flash_seq_tb;
    localparam int T_WLO  = (45 + 7) / 8;
    localparam int T_WHI  = (20 + 7) / 8;
    localparam int T_RD   = (90 + 7) / 8;
    localparam int T_RST  = (500 + 7) / 8;
    localparam int TMO_US = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        cmd_valid = 1'b0, cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [20:0] cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic        rsp_valid, rsp_timeout;
    logic [15:0] rsp_rdata;
    logic [20:0] fl_addr;
    logic [15:0] fl_dq_out, fl_dq_in;
    logic        fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n, fl_ready, fl_rst_n;

    flash_seq #(.PROG_TMO_US(TMO_US), .SECT_TMO_US(40), .CHIP_TMO_US(60)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_ready(fl_ready),
        .fl_rst_n(fl_rst_n)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural flash model and bus monitor
    logic [15:0] mem [0:255];
    logic [20:0] wq_a[$];
    logic [15:0] wq_d[$];
    logic [20:0] rq_a[$];
    int  cyc = 0, we_lo = 0, we_hi = 1000, oe_lo = 0, rst_lo = 0, last_rst = 0;
    int  busy_rdy = 0, busy_dq = 0, busy_start = 0;
    int  exp_writes = 0, cfg_rdy = 0, cfg_dq = 0, rsp_cnt = 0;
    bit  stuck = 0, cur_prog = 0;
    logic [20:0] lat_a, lat_ra, cur_a;
    logic [15:0] lat_d, cur_d, busy_word = '0;

    assign fl_ready = !stuck && (busy_rdy == 0);
    assign fl_dq_in = (stuck || busy_dq != 0) ? busy_word : mem[fl_addr[7:0]];

    initial for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;

    always @(negedge clk) begin
        cyc++;
        if (busy_rdy > 0) busy_rdy--;
        if (busy_dq > 0)  busy_dq--;
        if (rsp_valid) rsp_cnt++;
        if (!fl_rst_n) begin
            rst_lo++; busy_rdy = 0; busy_dq = 0;
        end else if (rst_lo > 0) begin
            last_rst = rst_lo; rst_lo = 0;
        end
        if (!fl_we_n) begin
            if (we_lo == 0) chk(we_hi >= T_WHI, "R5", "we high gap", we_hi, T_WHI);
            we_lo++; lat_a = fl_addr; lat_d = fl_dq_out;
        end else begin
            if (we_lo > 0) begin
                chk(we_lo == T_WLO, "R5", "we low width", we_lo, T_WLO);
                wq_a.push_back(lat_a); wq_d.push_back(lat_d);
                we_hi = 0;
                if (wq_a.size() == exp_writes) begin
                    busy_rdy = cfg_rdy; busy_dq = cfg_dq; busy_start = cyc;
                    busy_word = (cur_prog ? cur_d : 16'hFFFF) ^ 16'h0080;
                    if (cur_prog) mem[cur_a[7:0]] = cur_d;
                end
            end
            we_lo = 0; we_hi++;
        end
        if (!fl_oe_n) begin
            oe_lo++; lat_ra = fl_addr;
        end else if (oe_lo > 0) begin
            chk(oe_lo == T_RD, "R6", "oe low width", oe_lo, T_RD);
            rq_a.push_back(lat_ra); oe_lo = 0;
        end
    end

    bit          r_tmo;
    logic [15:0] r_data;
    int          r_lat, n_cmds = 0;

    task automatic do_cmd(input logic [1:0] op, input logic [20:0] a, input logic [15:0] d,
                          input int nw, input int rdy, input int dqc, input bit stk);
        int n;
        while (!cmd_ready) @(negedge clk);
        wq_a.delete(); wq_d.delete(); rq_a.delete();
        exp_writes = nw; cfg_rdy = rdy; cfg_dq = dqc; stuck = stk;
        cur_prog = (op == 2'd1); cur_a = a; cur_d = d; busy_start = cyc;
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        n_cmds++;
        chk(!cmd_ready, "R9", "ready after accept", cmd_ready, 0);
        // offered while busy: must be dropped
        cmd_op = 2'd1; cmd_addr = 21'h0_0077; cmd_wdata = 16'h1234;
        repeat (5) @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 20000) begin @(negedge clk); n++; end
        chk(rsp_valid, "R10", "response seen", rsp_valid, 1);
        r_tmo = rsp_timeout; r_data = rsp_rdata; r_lat = cyc - busy_start;
        @(negedge clk);
        chk(!rsp_valid, "R10", "response one cycle", rsp_valid, 0);
        chk(cmd_ready, "R9", "ready after response", cmd_ready, 1);
    endtask

    task automatic check_writes(input string req, input logic [1:0] op,
                                input logic [20:0] a, input logic [15:0] d);
        logic [20:0] ea [6];
        logic [15:0] ed [6];
        int nw;
        ea = '{21'h5555, 21'h2AAA, 21'h5555, 21'h5555, 21'h2AAA, 21'h0};
        ed = '{16'h00AA, 16'h0055, 16'h0080, 16'h00AA, 16'h0055, 16'h0};
        if (op == 2'd1) begin
            nw = 4; ed[2] = 16'h00A0; ea[3] = a; ed[3] = d;
        end else begin
            nw = 6;
            if (op == 2'd2) begin ea[5] = a; ed[5] = 16'h0030; end
            else            begin ea[5] = 21'h5555; ed[5] = 16'h0010; end
        end
        chk(wq_a.size() == nw, req, "write count", wq_a.size(), nw);
        for (int i = 0; i < nw && i < wq_a.size(); i++) begin
            chk(wq_a[i] == ea[i], req, $sformatf("write %0d addr", i), wq_a[i], ea[i]);
            chk(wq_d[i] == ed[i], req, $sformatf("write %0d data", i), wq_d[i], ed[i]);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle pins, not ready, flash reset asserted
        chk(fl_we_n && fl_oe_n && fl_ce_n, "R1", "strobes idle", {fl_we_n, fl_oe_n, fl_ce_n}, 3'b111);
        chk(!cmd_ready, "R1", "ready during reset", cmd_ready, 0);
        chk(!fl_rst_n, "R1", "flash reset low", fl_rst_n, 0);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        chk(last_rst >= T_RST, "R1", "reset pulse width", last_rst, T_RST);

        // R2 + R7: program, bit7 = 0, ready low for a while
        do_cmd(2'd1, 21'h1_0012, 16'h5A3C, 4, 40, 40, 0);
        check_writes("R2", 2'd1, 21'h1_0012, 16'h5A3C);
        chk(!r_tmo, "R2", "no timeout", r_tmo, 0);
        chk(r_lat >= 40, "R7", "waits for ready", r_lat, 40);
        chk(rq_a.size() >= 1 && rq_a[0] == 21'h1_0012, "R7", "poll address",
            (rq_a.size() > 0) ? rq_a[0] : 21'h0, 21'h1_0012);

        // R7: ready early, status bit lags -> repeated polls; bit7 = 1
        do_cmd(2'd1, 21'h0_ABCD, 16'hC3F1, 4, 0, 300, 0);
        check_writes("R2", 2'd1, 21'h0_ABCD, 16'hC3F1);
        chk(rq_a.size() > 1, "R7", "repeated polls", rq_a.size(), 2);
        chk(r_lat >= 300, "R7", "waits for status bit", r_lat, 300);
        chk(!r_tmo, "R7", "no timeout", r_tmo, 0);

        // R6: read, with R9 intrusion dropped
        do_cmd(2'd0, 21'h1_2312, 16'h0000, 99, 0, 0, 0);
        chk(r_data == 16'h5A3C, "R6", "read data", r_data, 16'h5A3C);
        chk(wq_a.size() == 0, "R6", "no writes on read", wq_a.size(), 0);
        chk(rq_a.size() == 1, "R9", "single read strobe", rq_a.size(), 1);
        chk(!r_tmo, "R6", "no timeout", r_tmo, 0);

        // R3: sector erase
        do_cmd(2'd2, 21'h0A_8000, 16'h0000, 6, 100, 0, 0);
        check_writes("R3", 2'd2, 21'h0A_8000, 16'h0);
        chk(!r_tmo && r_lat >= 100, "R3", "erase completes after busy", r_lat, 100);

        // R4: chip erase
        do_cmd(2'd3, 21'h00_0000, 16'h0000, 6, 60, 20, 0);
        check_writes("R4", 2'd3, 21'h0, 16'h0);
        chk(!r_tmo, "R4", "no timeout", r_tmo, 0);

        // R8: program that never completes
        last_rst = 0;
        do_cmd(2'd1, 21'h0_0033, 16'h0011, 4, 0, 0, 1);
        chk(r_tmo, "R8", "timeout reported", r_tmo, 1);
        chk(r_lat >= TMO_US * 125, "R8", "timeout not early", r_lat, TMO_US * 125);
        chk(r_lat <= TMO_US * 125 + T_RST + 200, "R8", "timeout not late", r_lat, TMO_US * 125);
        chk(last_rst >= T_RST, "R8", "reset pulse after timeout", last_rst, T_RST);
        stuck = 0;

        // R8: back in service
        do_cmd(2'd0, 21'h0_ABCD, 16'h0000, 99, 0, 0, 0);
        chk(r_data == 16'hC3F1 && !r_tmo, "R8", "read after recovery", r_data, 16'hC3F1);

        repeat (10) @(negedge clk);
        chk(rsp_cnt == n_cmds, "R10", "one response per request", rsp_cnt, n_cmds);
        chk(fl_oe_n && fl_we_n, "R11", "strobes idle at end", {fl_oe_n, fl_we_n}, 2'b11);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule